// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detection

This block turns an addressing mode and its operand bytes into the 16-bit effective address that a byte-wide processor core uses for its next data access or branch. It covers ten modes: zero page, zero page plus X, zero page plus Y, absolute, absolute plus X, absolute plus Y, pointer indexed by X before the read, pointer indexed by Y after the read, indirect jump through a 16-bit pointer, and relative branch. Each result comes with a count of the extra cycles that the core must add for a page crossing or a taken branch.

The core presents one request for one cycle on `start`. The block latches the request. Modes that need no pointer read finish on the accepting edge. The three pointer modes fetch two bytes, low byte first, over a read port with one cycle of latency, and then finish. While a fetch is in progress the block is busy, and any new request is dropped. The data operation that uses the address is outside this block.

Top module: `eag_core`

## Requirements
- R1: Mode codes are 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 pre-indexed pointer, 7 post-indexed pointer, 8 indirect jump, 9 relative; codes 10 to 15 behave as absolute. Zero page gives `{8'h00, lo}`. Zero page indexed gives `{8'h00, (lo + index) mod 256}`, so the high byte is always 0x00.
- R2: Absolute gives `{hi, lo}`. Absolute indexed gives `({hi, lo} + index) mod 65536`.
- R3: For absolute+X, absolute+Y and post-indexed modes, `extra` is 1 when `pen_ok` was set with the request and the high byte of the base differs from the high byte of the result; otherwise it is 0.
- R4: Pre-indexed mode forms the pointer `(lo + X) mod 256`, reads the low byte at the pointer and the high byte at pointer+1 mod 65536, and returns that little-endian word.
- R5: Post-indexed mode reads a little-endian word at `{8'h00, lo}` and pointer+1 mod 65536, and returns `(word + Y) mod 65536`.
- R6: Indirect jump reads a little-endian word at `{hi, lo}` and at that address +1 mod 65536 (0xFFFF is followed by 0x0000). It returns that word with `extra` 0.
- R7: Relative mode with `br_taken` set returns `pc_next + sign-extended lo` mod 65536, with `extra` 1 when the target is on the same page as `pc_next` and 2 otherwise. Without `br_taken` it returns `pc_next` with `extra` 0.
- R8: Non-pointer modes raise `done` for one cycle right after the accepting edge and never assert `rd_req`. Pointer modes assert `rd_req` in exactly two consecutive cycles (low, then high) and raise `done` after the fourth rising edge, counting the accepting edge.
- R9: A `start` that arrives while `busy` is high is ignored. The result in flight is unchanged and no extra `done` follows.
- R10: After reset `done`, `busy`, `rd_req`, `ea` and `extra` are all zero.
- R11: Zero page, zero page indexed, absolute, pre-indexed and indirect jump modes always report `extra` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode | input | 4 | Addressing mode code (R1) |
| opnd_lo | input | 8 | First operand byte, or signed branch offset |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_next | input | 16 | Address following the branch offset byte |
| pen_ok | input | 1 | Opcode may take a page-cross penalty |
| br_taken | input | 1 | Branch condition is met |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| extra | output | 2 | Extra cycles due |

## Verification
The hardest situations to reach from the ports are a pointer whose second byte lies across a 64 KiB or page boundary, and a new request that lands during the short fetch window. Directed cases place pointers at 0x00FF and 0xFFFF, index an absolute base past 0xFFFF, and branch backward across a page. The memory model returns a byte computed from its address, so a wrong high-byte address changes the result. On every pointer operation, randomly chosen or directed, the bench also pulses a conflicting zero-page request in the middle of the fetch, then checks that the result is unchanged and that no second strobe appears.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_ZP     = 4'd0,
    AM_ZPX    = 4'd1,
    AM_ZPY    = 4'd2,
    AM_ABS    = 4'd3,
    AM_ABSX   = 4'd4,
    AM_ABSY   = 4'd5,
    AM_PREIX  = 4'd6,
    AM_POSTIY = 4'd7,
    AM_JIND   = 4'd8,
    AM_REL    = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2,
    F_FIN  = 2'd3
  } fstate_e;

  function automatic logic needs_fetch(input logic [MODE_W-1:0] m);
    return (m == AM_PREIX) || (m == AM_POSTIY) || (m == AM_JIND);
  endfunction

  function automatic logic uses_y(input logic [MODE_W-1:0] m);
    return (m == AM_ZPY) || (m == AM_ABSY);
  endfunction
endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int DATA_W    = 8,
  parameter bit WRAP_PAGE = 1'b0
) (
  input  logic [2*DATA_W-1:0] base,
  input  logic [DATA_W-1:0]   idx,
  output logic [2*DATA_W-1:0] sum,
  output logic                crossed
);
  localparam int AW = 2 * DATA_W;

  generate
    if (WRAP_PAGE) begin : g_wrap
      // index stays inside the page of the base
      logic [DATA_W-1:0] low_sum;
      assign low_sum = base[DATA_W-1:0] + idx;
      assign sum     = {base[AW-1:DATA_W], low_sum};
      assign crossed = 1'b0;
    end else begin : g_full
      assign sum     = base + AW'(idx);
      assign crossed = (sum[AW-1:DATA_W] != base[AW-1:DATA_W]);
    end
  endgenerate
endmodule

// File: rtl/eag_rel_target.sv
module eag_rel_target #(
  parameter int DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] pc,
  input  logic [DATA_W-1:0]   off,
  input  logic                taken,
  output logic [2*DATA_W-1:0] dest,
  output logic [1:0]          extra
);
  localparam int AW = 2 * DATA_W;

  logic [AW-1:0] target;
  logic          far;

  assign target = pc + {{(AW-DATA_W){off[DATA_W-1]}}, off};
  assign far    = (target[AW-1:DATA_W] != pc[AW-1:DATA_W]);

  always_comb begin
    if (taken) begin
      dest  = target;
      extra = far ? 2'd2 : 2'd1;
    end else begin
      dest  = pc;
      extra = 2'd0;
    end
  end
endmodule

// File: rtl/eag_ptr_fetch.sv
module eag_ptr_fetch
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [2*DATA_W-1:0] ptr,
  output logic                busy,
  output logic                rd_req,
  output logic [2*DATA_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                word_vld,
  output logic [2*DATA_W-1:0] word
);
  localparam int AW = 2 * DATA_W;

  fstate_e           state;
  logic [AW-1:0]     ptr_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= F_IDLE;
      ptr_q <= '0;
      lo_q  <= '0;
    end else begin
      case (state)
        F_IDLE: if (go) begin
          ptr_q <= ptr;
          state <= F_LO;
        end
        F_LO:   state <= F_HI;
        F_HI: begin
          lo_q  <= rd_data;
          state <= F_FIN;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  assign busy     = (state != F_IDLE);
  assign rd_req   = (state == F_LO) || (state == F_HI);
  assign rd_addr  = (state == F_HI) ? ptr_q + AW'(1) : ptr_q;
  assign word_vld = (state == F_FIN);
  assign word     = {rd_data, lo_q};

  // R6: second byte address follows the first, wrapping at the top
  a_r6_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + AW'(1)));

  // R8: reads come as exactly one low/high pair
  a_r8_read_pair: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req)) |=> !rd_req);

  a_r8_read_starts_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |=> rd_req);
endmodule

// File: rtl/eag_core.sv
module eag_core
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [MODE_W-1:0]     mode,
  input  logic [DATA_W-1:0]     opnd_lo,
  input  logic [DATA_W-1:0]     opnd_hi,
  input  logic [DATA_W-1:0]     idx_x,
  input  logic [DATA_W-1:0]     idx_y,
  input  logic [2*DATA_W-1:0]   pc_next,
  input  logic                  pen_ok,
  input  logic                  br_taken,
  output logic                  rd_req,
  output logic [2*DATA_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  busy,
  output logic                  done,
  output logic [2*DATA_W-1:0]   ea,
  output logic [1:0]            extra
);
  localparam int AW = 2 * DATA_W;

  logic              accept;
  logic [DATA_W-1:0] zp_idx, abs_idx;
  logic [AW-1:0]     zp_sum, abs_sum, ind_sum, rel_ea, f_ptr, f_word;
  logic              zp_cross, abs_cross, ind_cross;
  logic [1:0]        rel_extra;
  logic              f_busy, f_vld;
  logic [AW-1:0]     dir_ea;
  logic [1:0]        dir_extra;

  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] y_q;
  logic              pen_q;

  assign accept  = start && !f_busy;
  assign busy    = f_busy;
  assign zp_idx  = (mode == AM_ZPY) ? idx_y : idx_x;
  assign abs_idx = uses_y(mode) ? idx_y : idx_x;

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b1)) u_zp_add (
    .base({{DATA_W{1'b0}}, opnd_lo}), .idx(zp_idx), .sum(zp_sum), .crossed(zp_cross)
  );

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b0)) u_abs_add (
    .base({opnd_hi, opnd_lo}), .idx(abs_idx), .sum(abs_sum), .crossed(abs_cross)
  );

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b0)) u_ind_add (
    .base(f_word), .idx(y_q), .sum(ind_sum), .crossed(ind_cross)
  );

  eag_rel_target #(.DATA_W(DATA_W)) u_rel (
    .pc(pc_next), .off(opnd_lo), .taken(br_taken), .dest(rel_ea), .extra(rel_extra)
  );

  always_comb begin
    case (mode)
      AM_PREIX:  f_ptr = zp_sum;
      AM_POSTIY: f_ptr = {{DATA_W{1'b0}}, opnd_lo};
      default:   f_ptr = {opnd_hi, opnd_lo};
    endcase
  end

  eag_ptr_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst(rst), .go(accept && needs_fetch(mode)), .ptr(f_ptr),
    .busy(f_busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .word_vld(f_vld), .word(f_word)
  );

  always_comb begin
    dir_ea    = {opnd_hi, opnd_lo};
    dir_extra = 2'd0;
    case (mode)
      AM_ZP:            dir_ea = {{DATA_W{1'b0}}, opnd_lo};
      AM_ZPX, AM_ZPY:   dir_ea = zp_sum;
      AM_ABSX, AM_ABSY: begin
        dir_ea    = abs_sum;
        dir_extra = {1'b0, pen_ok && abs_cross};
      end
      AM_REL: begin
        dir_ea    = rel_ea;
        dir_extra = rel_extra;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      ea     <= '0;
      extra  <= 2'd0;
      mode_q <= '0;
      y_q    <= '0;
      pen_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        y_q    <= idx_y;
        pen_q  <= pen_ok;
      end
      if (accept && !needs_fetch(mode)) begin
        ea    <= dir_ea;
        extra <= dir_extra;
        done  <= 1'b1;
      end else if (f_vld) begin
        if (mode_q == AM_POSTIY) begin
          ea    <= ind_sum;
          extra <= {1'b0, pen_q && ind_cross};
        end else begin
          ea    <= f_word;
          extra <= 2'd0;
        end
        done <= 1'b1;
      end
    end
  end

  // R1: zero page results never leave page zero
  a_r1_zp_page: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q inside {AM_ZP, AM_ZPX, AM_ZPY})) |-> (ea[AW-1:DATA_W] == '0));

  // R11: modes without a penalty report no extra cycles
  a_r11_no_penalty: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q inside {AM_ZP, AM_ZPX, AM_ZPY, AM_ABS, AM_PREIX, AM_JIND}))
      |-> (extra == 2'd0));

  // R3: page-cross penalty is at most one cycle outside branches
  a_r3_one_cycle_max: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q != AM_REL) |-> (extra <= 2'd1));

  // R9: a request during a fetch leaves the latched mode alone
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));

  // R8: no reads outside a fetch
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req);

  // R7: branch penalty never exceeds two cycles
  a_r7_branch_range: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == AM_REL) |-> (extra != 2'd3));
endmodule

// File: tb/sim_eag_core.sv
module sim_eag_core;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
    M_ABSX = 4'd4, M_ABSY = 4'd5, M_PRE = 4'd6, M_POST = 4'd7, M_JIND = 4'd8, M_REL = 4'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [DW-1:0] opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [AW-1:0] pc_next = '0;
  logic          pen_ok = 1'b0, br_taken = 1'b0;
  logic          rd_req, busy, done;
  logic [AW-1:0] rd_addr, ea;
  logic [DW-1:0] rd_data = '0;
  logic [1:0]    extra;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  eag_core #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
    .pen_ok(pen_ok), .br_taken(br_taken), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .ea(ea), .extra(extra)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

  function automatic logic [15:0] wordf(input logic [15:0] p);
    return {memf(p + 16'd1), memf(p)};
  endfunction

  task automatic model(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                       input logic pen, input logic tkn,
                       output logic [15:0] e, output logic [1:0] ex, output int lat, output int rds);
    logic [15:0] base;
    logic [7:0]  p8;
    ex = 2'd0; lat = 1; rds = 0;
    case (m)
      M_ZP:  e = {8'h00, lo};
      M_ZPX: begin p8 = lo + x; e = {8'h00, p8}; end
      M_ZPY: begin p8 = lo + y; e = {8'h00, p8}; end
      M_ABSX, M_ABSY: begin
        base = {hi, lo};
        e = base + {8'h00, (m == M_ABSX) ? x : y};
        ex = {1'b0, pen && (e[15:8] != base[15:8])};
      end
      M_PRE: begin p8 = lo + x; e = wordf({8'h00, p8}); lat = 4; rds = 2; end
      M_POST: begin
        base = wordf({8'h00, lo});
        e = base + {8'h00, y};
        ex = {1'b0, pen && (e[15:8] != base[15:8])};
        lat = 4; rds = 2;
      end
      M_JIND: begin e = wordf({hi, lo}); lat = 4; rds = 2; end
      M_REL: begin
        if (tkn) begin
          e = pc + {{8{lo[7]}}, lo};
          ex = (e[15:8] != pc[15:8]) ? 2'd2 : 2'd1;
        end else e = pc;
      end
      default: e = {hi, lo};
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                        input logic pen, input logic tkn, input string req);
    logic [15:0] e_exp, e_got;
    logic [1:0]  x_exp, x_got;
    int lat_exp, rd_exp, lat, reads;
    bit poke;
    model(m, lo, hi, x, y, pc, pen, tkn, e_exp, x_exp, lat_exp, rd_exp);
    poke = (lat_exp > 1);
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y;
    pc_next = pc; pen_ok = pen; br_taken = tkn; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; reads = 0;
    while (1) begin
      if (rd_req) reads++;
      if (done || lat >= 12) break;
      if (poke && lat == 2) begin
        // R9: conflicting request in the middle of the fetch
        start = 1'b1; mode = M_ZP; opnd_lo = ~lo;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    e_got = ea; x_got = extra;
    chk(e_got == e_exp, req, {16'h0, e_got}, {16'h0, e_exp});
    chk(x_got == x_exp, {req, " extra"}, {30'h0, x_got}, {30'h0, x_exp});
    chk(lat == lat_exp, "R8 latency", lat, lat_exp);
    chk(reads == rd_exp, "R8 read count", reads, rd_exp);
    if (poke) begin
      @(negedge clk);
      chk(!done && ea == e_exp, "R9 ignored start", {15'h0, done, ea}, {16'h0, e_exp});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        finish_up();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !busy && !rd_req && ea == '0 && extra == '0, "R10 reset",
        {12'h0, done, busy, rd_req, extra[0], ea}, 32'h0);
    rst = 1'b0;

    // directed corners
    run_op(M_ZP,   8'h7E, 8'h33, 8'h00, 8'h00, 16'h0, 1'b1, 1'b0, "R1 zero page");
    run_op(M_ZPX,  8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b1, 1'b0, "R1 zp+X wrap");
    run_op(M_ZPY,  8'hFF, 8'h12, 8'h00, 8'h01, 16'h0, 1'b1, 1'b0, "R1 zp+Y wrap");
    run_op(4'd12,  8'h34, 8'h12, 8'h05, 8'h05, 16'h0, 1'b1, 1'b0, "R1 spare code as absolute");
    run_op(M_ABS,  8'hCD, 8'hAB, 8'h10, 8'h10, 16'h0, 1'b1, 1'b0, "R2 absolute");
    run_op(M_ABSX, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b1, 1'b0, "R3 abs+X cross eligible");
    run_op(M_ABSX, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 1'b0, "R3 abs+X cross not eligible");
    run_op(M_ABSY, 8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0, 1'b1, 1'b0, "R2 abs+Y 64K wrap");
    run_op(M_ABSY, 8'h10, 8'h40, 8'h00, 8'h20, 16'h0, 1'b1, 1'b0, "R3 abs+Y same page");
    run_op(M_PRE,  8'hFE, 8'h00, 8'h01, 8'h00, 16'h0, 1'b1, 1'b0, "R4 pointer at 00FF");
    run_op(M_PRE,  8'h80, 8'h00, 8'h90, 8'h00, 16'h0, 1'b1, 1'b0, "R4 pointer index wrap");
    run_op(M_POST, 8'h22, 8'h00, 8'h00, 8'hFF, 16'h0, 1'b1, 1'b0, "R5 post-indexed");
    run_op(M_POST, 8'hFF, 8'h00, 8'h00, 8'h80, 16'h0, 1'b0, 1'b0, "R5 post-indexed at 00FF");
    run_op(M_JIND, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0, 1'b1, 1'b0, "R6 jump pointer FFFF");
    run_op(M_JIND, 8'hFF, 8'h30, 8'h00, 8'h00, 16'h0, 1'b1, 1'b0, "R6 jump pointer page end");
    run_op(M_REL,  8'hF0, 8'h00, 8'h00, 8'h00, 16'h1005, 1'b0, 1'b1, "R7 back across page");
    run_op(M_REL,  8'h10, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b0, 1'b1, "R7 forward same page");
    run_op(M_REL,  8'h10, 8'h00, 8'h00, 8'h00, 16'h10F8, 1'b0, 1'b0, "R7 not taken");
    run_op(M_REL,  8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 1'b0, 1'b1, "R7 forward wrap");
    run_op(M_PRE,  8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0, 1'b0, "R11 pre-indexed no penalty");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 11));
      run_op(m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             16'($urandom), 1'($urandom), 1'($urandom), "R2 R5 R7 random");
    end

    // R10: reset again mid-stream clears outputs
    @(negedge clk);
    mode = M_JIND; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !rd_req && ea == '0 && extra == '0, "R10 reset during fetch",
        {12'h0, done, busy, rd_req, extra[0], ea}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    finish_up();
  end
endmodule